// File: doc/BRIEF.md
# Conditional Branch Direction and Target Predictor

This block predicts, in the same cycle as the fetch address is presented, whether a conditional branch will be taken and where it goes. It keeps a direct-mapped table of branch entries, each with a tag, a target, a small loop-trip detector and a short local outcome history. The history selects one of sixteen shared 2-bit saturating counters. When the fetch address finds no entry, the block falls back on a static rule driven by the sign of the decoded displacement.

A separate resolve port reports, for each executed conditional branch, its address, actual direction, actual target and displacement sign. A branch that hits its entry always trains it. A branch that misses is written into the table only when the static rule got it wrong. The loop detector counts taken outcomes between two not-taken outcomes. Once two consecutive executions give the same count, the entry predicts the loop exit exactly. An entry whose loop prediction is ever wrong stops using loop mode and relies on its history counters.

Top module: `bp_predictor`

## Requirements
- R1: After reset no entry is valid, and every 2-bit counter holds the weakly-not-taken value, so a single taken update at a history value makes that history value predict taken.
- R2: A branch lookup whose entry is missing predicts taken when the displacement is backward (fetch_backward=1) and not taken when it is forward, with pred_hit=0 and pred_target=0.
- R3: A lookup with fetch_is_branch=0 gives pred_taken=0 and pred_hit=0.
- R4: A resolve that misses the table writes an entry only if the static rule would have mispredicted it (res_taken differs from res_backward). A correctly predicted miss leaves the table unchanged.
- R5: A hit supplies the stored target in the same cycle as the direction. A taken resolve of a hitting branch replaces the stored target with res_target.
- R6: A loop branch with a trip count from 1 to 16 is predicted with no misprediction, exit included, once two consecutive executions have shown the same trip count.
- R7: A loop branch with a trip count above 16 is mispredicted exactly once per execution after training, at its final (not-taken) iteration.
- R8: A taken/not-taken sequence repeating with a period of 1 to 4 is predicted with no misprediction after training. This includes sequences that look briefly like a loop, because an entry leaves loop mode for good once its loop prediction fails.
- R9: A resolve in the same cycle as a lookup of the same entry does not change that lookup's result. Its effect is visible from the next cycle.
- R10: The entry index is pc[ALIGN+IDX_W-1:ALIGN] and the tag is the address bits above it. An address with the same index but a different tag misses and follows the static rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc | input | PC_W | Address looked up this cycle |
| fetch_is_branch | input | 1 | The fetched instruction is a conditional branch |
| fetch_backward | input | 1 | Decoded displacement is negative |
| pred_taken | output | 1 | Predicted direction |
| pred_hit | output | 1 | The lookup found a matching entry |
| pred_target | output | PC_W | Stored target on a hit, zero on a miss |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_backward | input | 1 | Displacement sign of the resolved branch |
| res_target | input | PC_W | Actual taken target |

## Verification
Loops are run with trip counts of 1, 3, 9 and 16. These show that exit prediction comes from the trip detector and not from the counters, and a trip count of 20 separates a single misprediction at the exit from one at the first iteration. Periodic sequences of period 1 to 4 are used: alternating, one-in-three, two-and-two, and three not-taken then one taken. The last looks like a loop for two periods and so tests the exit from loop mode. Same-cycle resolve and lookup, a correctly predicted miss, an aliasing address, and the first update of a fresh counter each probe one table-write corner.

// File: rtl/bp_pkg.sv
package bp_pkg;

  localparam int HW = 4;   // local history bits, also pattern table index width
  localparam int LW = 4;   // loop counter width, trip counts 1..2**LW

  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  typedef struct packed {
    logic [HW-1:0] hist;        // newest outcome in bit 0
    logic [LW-1:0] trip;        // taken outcomes per execution
    logic [LW-1:0] iter;        // taken outcomes seen in this execution
    logic          trip_known;  // trip holds a complete count
    logic          loop_ok;     // same count seen twice in a row
    logic          no_loop;     // loop mode failed once, never used again
    logic          ovf;         // iteration count passed the counter range
  } lp_state_t;

  function automatic logic [1:0] ctr_step(logic [1:0] c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic loop_active(lp_state_t s);
    return s.loop_ok && !s.no_loop;
  endfunction

  function automatic logic loop_dir(lp_state_t s);
    return s.iter != s.trip;
  endfunction

  function automatic lp_state_t lp_alloc(logic taken);
    lp_state_t n;
    n            = '0;
    n.hist       = {{(HW-1){1'b0}}, taken};
    n.iter       = {{(LW-1){1'b0}}, taken};
    return n;
  endfunction

  function automatic lp_state_t lp_next(lp_state_t s, logic taken);
    lp_state_t n;
    n      = s;
    n.hist = {s.hist[HW-2:0], taken};
    if (loop_active(s) && (loop_dir(s) != taken))
      n.no_loop = 1'b1;
    if (taken) begin
      if (!s.ovf) begin
        if (s.iter == {LW{1'b1}}) begin
          n.ovf     = 1'b1;
          n.loop_ok = 1'b0;
        end else begin
          n.iter = s.iter + {{(LW-1){1'b0}}, 1'b1};
        end
      end
    end else begin
      if (!s.ovf && s.trip_known && (s.iter == s.trip)) begin
        n.loop_ok = 1'b1;
      end else begin
        n.loop_ok    = 1'b0;
        n.trip       = s.iter;
        n.trip_known = !s.ovf;
      end
      n.iter = '0;
      n.ovf  = 1'b0;
    end
    return n;
  endfunction

endpackage

// File: rtl/bp_pht.sv
module bp_pht
  import bp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] rd_idx,
  output logic [1:0]    rd_ctr,
  input  logic          upd_en,
  input  logic [HW-1:0] upd_idx,
  input  logic          upd_taken
);
  localparam int DEPTH = 1 << HW;

  logic [1:0] ctr_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_NT;
    end else if (upd_en) begin
      ctr_q[upd_idx] <= ctr_step(ctr_q[upd_idx], upd_taken);
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

  // R8
  ctr_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en && upd_taken && (ctr_q[upd_idx] == 2'b11) |=> ctr_q[$past(upd_idx)] == 2'b11);

endmodule

// File: rtl/bp_btb.sv
module bp_btb
  import bp_pkg::*;
#(
  parameter int ENTRIES = 4096,
  parameter int TAG_W   = 18,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] a_idx,
  output logic             a_valid,
  output logic [TAG_W-1:0] a_tag,
  output logic [PC_W-1:0]  a_tgt,
  output lp_state_t        a_st,
  input  logic [IDX_W-1:0] b_idx,
  output logic             b_valid,
  output logic [TAG_W-1:0] b_tag,
  output logic [PC_W-1:0]  b_tgt,
  output lp_state_t        b_st,
  input  logic             w_en,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  logic [PC_W-1:0]  w_tgt,
  input  lp_state_t        w_st
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [PC_W-1:0]    tgt_mem [ENTRIES];
  lp_state_t          st_mem  [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    valid_q        <= '0;
    else if (w_en) valid_q[w_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (w_en) begin
      tag_mem[w_idx] <= w_tag;
      tgt_mem[w_idx] <= w_tgt;
      st_mem[w_idx]  <= w_st;
    end
  end

  assign a_valid = valid_q[a_idx];
  assign a_tag   = tag_mem[a_idx];
  assign a_tgt   = tgt_mem[a_idx];
  assign a_st    = st_mem[a_idx];
  assign b_valid = valid_q[b_idx];
  assign b_tag   = tag_mem[b_idx];
  assign b_tgt   = tgt_mem[b_idx];
  assign b_st    = st_mem[b_idx];

  // R4
  write_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    w_en |=> valid_q[$past(w_idx)]);

endmodule

// File: rtl/bp_update.sv
module bp_update
  import bp_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            res_valid,
  input  logic            res_hit,
  input  logic            res_taken,
  input  logic            res_backward,
  input  logic [PC_W-1:0] res_target,
  input  logic [PC_W-1:0] old_tgt,
  input  lp_state_t       old_st,
  output logic            w_en,
  output logic [PC_W-1:0] w_tgt,
  output lp_state_t       w_st,
  output logic            pht_en
);
  logic miss_wrong;

  assign miss_wrong = res_valid && !res_hit && (res_taken != res_backward);
  assign w_en       = (res_valid && res_hit) || miss_wrong;
  assign pht_en     = res_valid && res_hit;

  always_comb begin
    if (res_hit) begin
      w_tgt = res_taken ? res_target : old_tgt;
      w_st  = lp_next(old_st, res_taken);
    end else begin
      w_tgt = res_target;
      w_st  = lp_alloc(res_taken);
    end
  end

endmodule

// File: rtl/bp_predictor.sv
module bp_predictor
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 4096,
  parameter int ALIGN   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  input  logic            fetch_is_branch,
  input  logic            fetch_backward,
  output logic            pred_taken,
  output logic            pred_hit,
  output logic [PC_W-1:0] pred_target,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic            res_backward,
  input  logic [PC_W-1:0] res_target
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = PC_W - ALIGN - IDX_W;

  // address split
  logic [IDX_W-1:0] lu_idx, rs_idx;
  logic [TAG_W-1:0] lu_tag, rs_tag;
  assign lu_idx = fetch_pc[ALIGN +: IDX_W];
  assign lu_tag = fetch_pc[PC_W-1 -: TAG_W];
  assign rs_idx = res_pc[ALIGN +: IDX_W];
  assign rs_tag = res_pc[PC_W-1 -: TAG_W];

  // table ports
  logic             a_valid, b_valid;
  logic [TAG_W-1:0] a_tag, b_tag;
  logic [PC_W-1:0]  a_tgt, b_tgt;
  lp_state_t        a_st, b_st;
  logic             w_en;
  logic [PC_W-1:0]  w_tgt;
  lp_state_t        w_st;
  logic             pht_en;
  logic [1:0]       lu_ctr;

  // named events
  logic lu_hit, lu_loop, rs_hit;
  assign lu_hit  = fetch_is_branch && a_valid && (a_tag == lu_tag);
  assign lu_loop = loop_active(a_st);
  assign rs_hit  = res_valid && b_valid && (b_tag == rs_tag);

  bp_btb #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PC_W(PC_W)) u_btb (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_idx   (lu_idx),
    .a_valid (a_valid),
    .a_tag   (a_tag),
    .a_tgt   (a_tgt),
    .a_st    (a_st),
    .b_idx   (rs_idx),
    .b_valid (b_valid),
    .b_tag   (b_tag),
    .b_tgt   (b_tgt),
    .b_st    (b_st),
    .w_en    (w_en),
    .w_idx   (rs_idx),
    .w_tag   (rs_tag),
    .w_tgt   (w_tgt),
    .w_st    (w_st)
  );

  bp_pht u_pht (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (a_st.hist),
    .rd_ctr    (lu_ctr),
    .upd_en    (pht_en),
    .upd_idx   (b_st.hist),
    .upd_taken (res_taken)
  );

  bp_update #(.PC_W(PC_W)) u_upd (
    .res_valid    (res_valid),
    .res_hit      (rs_hit),
    .res_taken    (res_taken),
    .res_backward (res_backward),
    .res_target   (res_target),
    .old_tgt      (b_tgt),
    .old_st       (b_st),
    .w_en         (w_en),
    .w_tgt        (w_tgt),
    .w_st         (w_st),
    .pht_en       (pht_en)
  );

  // prediction
  always_comb begin
    pred_hit    = lu_hit;
    pred_target = lu_hit ? a_tgt : '0;
    if (!fetch_is_branch)  pred_taken = 1'b0;
    else if (!lu_hit)      pred_taken = fetch_backward;
    else if (lu_loop)      pred_taken = loop_dir(a_st);
    else                   pred_taken = lu_ctr[1];
  end

  // R3
  nonbranch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_is_branch |-> !pred_taken && !pred_hit);

  // R2
  static_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_is_branch && !pred_hit |-> (pred_taken == fetch_backward) && (pred_target == '0));

  // R7
  ovf_not_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rs_hit |-> !(b_st.ovf && b_st.loop_ok));

endmodule

// File: tb/tb_bp_predictor.sv
module tb_bp_predictor;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_is_branch = 1'b0;
  logic        fetch_backward = 1'b0;
  logic        pred_taken, pred_hit;
  logic [31:0] pred_target;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic        res_backward = 1'b0;
  logic [31:0] res_target = '0;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  bp_predictor dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_pc(fetch_pc), .fetch_is_branch(fetch_is_branch), .fetch_backward(fetch_backward),
    .pred_taken(pred_taken), .pred_hit(pred_hit), .pred_target(pred_target),
    .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
    .res_backward(res_backward), .res_target(res_target)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // lookup only, no resolve
  task automatic look(input logic [31:0] pc, input logic br, input logic back);
    @(negedge clk);
    res_valid = 1'b0;
    fetch_pc = pc; fetch_is_branch = br; fetch_backward = back;
    #1;
  endtask

  // lookup and resolve of the same branch in one cycle
  task automatic step(input logic [31:0] pc, input logic back, input logic [31:0] tgt,
                      input logic taken, output logic mis);
    @(negedge clk);
    fetch_pc = pc; fetch_is_branch = 1'b1; fetch_backward = back;
    res_valid = 1'b1; res_pc = pc; res_taken = taken; res_backward = back; res_target = tgt;
    #1;
    mis = (pred_taken != taken) || (taken && pred_hit && pred_target != tgt);
    @(posedge clk);
  endtask

  task automatic run_loop(input logic [31:0] pc, input int trip,
                          output int mis_n, output logic last_mis);
    mis_n = 0; last_mis = 1'b0;
    for (int i = 0; i < trip; i++) begin
      logic m;
      step(pc, 1'b1, pc - 32'h40, (i != trip - 1), m);
      if (m) mis_n++;
      if (i == trip - 1) last_mis = m;
    end
  endtask

  task automatic run_pattern(input logic [31:0] pc, input logic [3:0] pat, input int per,
                             input int n, output int mis_n);
    mis_n = 0;
    for (int i = 0; i < n; i++) begin
      logic m;
      step(pc, 1'b1, pc - 32'h80, pat[i % per], m);
      if (m) mis_n++;
    end
  endtask

  task automatic t_reset_static();
    look(32'h0000_0100, 1'b1, 1'b1);
    chk(pred_hit == 1'b0, "R1 empty after reset", pred_hit, 0);
    chk(pred_taken == 1'b1, "R2 backward miss taken", pred_taken, 1);
    chk(pred_target == 32'h0, "R2 miss target zero", pred_target, 0);
    look(32'h0000_0100, 1'b1, 1'b0);
    chk(pred_taken == 1'b0, "R2 forward miss not taken", pred_taken, 0);
    look(32'h0000_0100, 1'b0, 1'b1);
    chk(pred_taken == 1'b0 && pred_hit == 1'b0, "R3 non-branch", {pred_taken, pred_hit}, 0);
  endtask

  task automatic t_alloc_and_timing();
    logic m;
    step(32'h0000_0200, 1'b0, 32'h0000_02A0, 1'b0, m);
    chk(m == 1'b0, "R4 forward not-taken correct", m, 0);
    look(32'h0000_0200, 1'b1, 1'b0);
    chk(pred_hit == 1'b0, "R4 correct miss not allocated", pred_hit, 0);
    // same-cycle resolve and lookup
    @(negedge clk);
    fetch_pc = 32'h0000_0200; fetch_is_branch = 1'b1; fetch_backward = 1'b0;
    res_valid = 1'b1; res_pc = 32'h0000_0200; res_taken = 1'b1; res_backward = 1'b0;
    res_target = 32'h0000_02A0;
    #1;
    chk(pred_hit == 1'b0, "R9 same-cycle lookup unchanged", pred_hit, 0);
    @(posedge clk); #1;
    chk(pred_hit == 1'b1, "R9 R4 visible next cycle", pred_hit, 1);
    chk(pred_target == 32'h0000_02A0, "R5 stored target", pred_target, 32'h2A0);
    look(32'h0000_0200, 1'b1, 1'b0);
    chk(pred_taken == 1'b0, "R1 fresh counter weakly not taken", pred_taken, 0);
    step(32'h0000_0200, 1'b0, 32'h0000_02B0, 1'b1, m);
    look(32'h0000_0200, 1'b1, 1'b0);
    chk(pred_target == 32'h0000_02B0, "R5 target replaced on taken", pred_target, 32'h2B0);
    step(32'h0000_0300, 1'b0, 32'h0000_03C0, 1'b1, m);
    look(32'h0000_0300, 1'b1, 1'b0);
    chk(pred_taken == 1'b1, "R1 one taken update flips counter", pred_taken, 1);
    chk(pred_target == 32'h0000_03C0, "R5 target on allocate", pred_target, 32'h3C0);
  endtask

  task automatic t_short_loop(input logic [31:0] pc, input int trip);
    int mn; logic lm;
    for (int e = 0; e < 4; e++) run_loop(pc, trip, mn, lm);
    for (int e = 0; e < 3; e++) begin
      run_loop(pc, trip, mn, lm);
      chk(mn == 0, $sformatf("R6 loop trip %0d mispredicts", trip), mn, 0);
    end
  endtask

  task automatic t_long_loop();
    int mn; logic lm;
    for (int e = 0; e < 4; e++) run_loop(32'h0000_2000, 20, mn, lm);
    for (int e = 0; e < 3; e++) begin
      run_loop(32'h0000_2000, 20, mn, lm);
      chk(mn == 1, "R7 long loop mispredict count", mn, 1);
      chk(lm == 1'b1, "R7 mispredict at exit", lm, 1);
    end
  endtask

  task automatic t_pattern(input logic [31:0] pc, input logic [3:0] pat, input int per);
    int mn;
    run_pattern(pc, pat, per, 48, mn);
    run_pattern(pc, pat, per, 24, mn);
    chk(mn == 0, $sformatf("R8 pattern %b period %0d", pat, per), mn, 0);
  endtask

  task automatic t_alias();
    look(32'h0000_4200, 1'b1, 1'b0);
    chk(pred_hit == 1'b0 && pred_taken == 1'b0, "R10 alias forward miss",
        {pred_hit, pred_taken}, 0);
    look(32'h0000_4200, 1'b1, 1'b1);
    chk(pred_hit == 1'b0 && pred_taken == 1'b1, "R10 alias backward miss",
        {pred_hit, pred_taken}, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset_static();
    t_alloc_and_timing();
    t_short_loop(32'h0000_1000, 1);
    t_short_loop(32'h0000_1100, 3);
    t_short_loop(32'h0000_1200, 16);
    t_short_loop(32'h0000_1300, 9);
    t_long_loop();
    t_pattern(32'h0000_3000, 4'b0000, 1);
    t_pattern(32'h0000_3100, 4'b0001, 2);
    t_pattern(32'h0000_3200, 4'b0001, 3);
    t_pattern(32'h0000_3300, 4'b0011, 4);
    t_pattern(32'h0000_3400, 4'b1000, 4);
    t_alias();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule